// File: doc/BRIEF.md
# Sleep Control Register with Guarded Detector-Off Bit

This block is an 8-bit control register that a CPU writes and reads through a simple register port. It holds a sleep-enable flag and a two-bit sleep mode. It turns a one-cycle sleep-instruction strobe into a sleep request that stays held until wake-up. The request carries the mode that was selected when the strobe arrived.

The register also holds a protected bit that asks for the brown-out detector to be switched off during sleep. That bit cannot be set by one plain write. Software must first write an unlock pattern, which opens a short window. It must then write the set pattern before that window closes. Once set, the bit waits a fixed delay before it becomes active, stays active for a fixed interval, and then clears itself. A sleep strobe that arrives during the active interval also raises the detector-off output for that sleep.

Top module: `sleep_ctl_reg`

## Requirements
- R1: After reset, `rd_data`, `sleep_req`, `sleep_mode` and `bod_off` are all zero.
- R2: Readback layout is as follows. Bit 0 is the stored sleep enable. Bits 2:1 are the stored mode. Bit 5 is the unlock-window flag. Bit 6 is the guarded detector-off bit. Bits 7, 4 and 3 always read zero. Every write stores bits 2:0.
- R3: A strobe on `sleep_strobe` has no effect while the stored sleep enable is 0. While it is 1 and no sleep is held, the strobe sets `sleep_req` on the next cycle.
- R4: `wake` clears `sleep_req` and `bod_off` on the next cycle. Strobes that arrive while a sleep is held are ignored.
- R5: A write with bit 6 = 1 and bit 5 = 1 opens the unlock window. Bit 5 then reads 1 for exactly WIN (4) cycles and clears itself.
- R6: A write with bit 6 = 1 and bit 5 = 0 sets bit 6 if it lands within 4 cycles after the unlock write. It is accepted when issued 1 to 4 cycles after the unlock write, and it closes the window.
- R7: A bit-6 set write with no open window leaves bit 6 unchanged. This covers a write with no prior unlock and a write 5 or more cycles after the unlock.
- R8: Once set, bit 6 reads 1 for 6 cycles. It is active in the 4th to 6th of those cycles (3 cycles after the set) and then clears itself.
- R9: The sleep taken on a strobe drives `bod_off` high only if the strobe comes while bit 6 is active. A strobe during the 3-cycle delay after the set gives `bod_off` = 0.
- R10: `sleep_mode` takes the stored mode at the accepted strobe and holds it. The encoding is 00 idle, 01 converter-quiet, 10 power-down and 11 power-save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| sleep_strobe | input | 1 | One-cycle sleep instruction pulse |
| wake | input | 1 | Wake-up event, ends a held sleep |
| sleep_req | output | 1 | Sleep request, held until wake |
| sleep_mode | output | 2 | Mode captured at the accepted strobe |
| bod_off | output | 1 | Detector-off request for the current sleep |

## Verification
The checker counts how long bits 5 and 6 stay high in a row. It assumes the only thing that can restart those runs is a write on the register port. It also assumes `wake` is a plain level that may arrive at any time, including when no sleep is held. The stimulus issues every write, strobe and wake as a single-cycle pulse on the falling edge. Unlock and set writes are spaced at chosen distances so that the window edges and each phase of the detector-off bit fall on known cycles.

// File: rtl/sleep_ctl_reg.sv
module sleep_ctl_reg #(
  parameter int WIN     = 4,
  parameter int ACT_DLY = 3,
  parameter int HOLD    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sleep_strobe,
  input  logic       wake,
  output logic       sleep_req,
  output logic [1:0] sleep_mode,
  output logic       bod_off
);
  localparam int WW   = $clog2(WIN + 1);
  localparam int LIFE = ACT_DLY + HOLD;
  localparam int BW   = $clog2(LIFE + 1);

  logic          se;
  logic [1:0]    mode;
  logic [WW-1:0] win_cnt;
  logic [BW-1:0] b_cnt;

  wire win_open    = (win_cnt != '0);
  wire unlock      = wr_en & wr_data[6] & wr_data[5];
  wire set_ok      = wr_en & wr_data[6] & ~wr_data[5] & win_open;
  wire bods        = (b_cnt != '0);
  wire bods_active = bods && (b_cnt <= BW'(HOLD));
  wire take_sleep  = sleep_strobe & se & ~sleep_req & ~wake;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      se   <= 1'b0;
      mode <= 2'b00;
    end else if (wr_en) begin
      se   <= wr_data[0];
      mode <= wr_data[2:1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        win_cnt <= '0;
    else if (unlock)   win_cnt <= WW'(WIN);
    else if (set_ok)   win_cnt <= '0;
    else if (win_open) win_cnt <= win_cnt - WW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      b_cnt <= '0;
    else if (set_ok) b_cnt <= BW'(LIFE);
    else if (bods)   b_cnt <= b_cnt - BW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sleep_req  <= 1'b0;
      sleep_mode <= 2'b00;
      bod_off    <= 1'b0;
    end else if (wake) begin
      sleep_req <= 1'b0;
      bod_off   <= 1'b0;
    end else if (take_sleep) begin
      sleep_req  <= 1'b1;
      sleep_mode <= mode;
      bod_off    <= bods_active;
    end

  assign rd_data = {1'b0, bods, win_open, 2'b00, mode, se};
endmodule

module sleep_ctl_reg_chk #(
  parameter int WIN     = 4,
  parameter int ACT_DLY = 3,
  parameter int HOLD    = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sleep_strobe,
  input logic       wake,
  input logic       sleep_req,
  input logic [1:0] sleep_mode,
  input logic       bod_off
);
  logic [7:0] run5, run6;
  wire reload5 = wr_en & wr_data[6] & wr_data[5];
  wire reload6 = wr_en & wr_data[6] & ~wr_data[5] & rd_data[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run5 <= '0;
      run6 <= '0;
    end else begin
      run5 <= reload5 ? 8'd0 : (rd_data[5] && run5 != 8'hFF) ? run5 + 8'd1 : (rd_data[5] ? run5 : 8'd0);
      run6 <= reload6 ? 8'd0 : (rd_data[6] && run6 != 8'hFF) ? run6 + 8'd1 : (rd_data[6] ? run6 : 8'd0);
    end

  assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] |-> run5 < 8'(WIN));
  assert_bods_life_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] |-> run6 < 8'(ACT_DLY + HOLD));
  assert_locked_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6] && !wr_data[5] && !rd_data[5] && !rd_data[6]) |=> !rd_data[6]);
  assert_no_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_strobe && !rd_data[0] && !sleep_req) |=> !sleep_req);
  assert_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_strobe && rd_data[0] && !sleep_req && !wake) |=> sleep_req);
  assert_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (!sleep_req && !bod_off));
  assert_bodoff_in_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bod_off |-> sleep_req);
  assert_bodoff_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bod_off) |-> ($past(sleep_strobe) && $past(rd_data[6])));
  assert_mode_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> sleep_mode == $past(rd_data[2:1]));
endmodule

bind sleep_ctl_reg sleep_ctl_reg_chk #(.WIN(WIN), .ACT_DLY(ACT_DLY), .HOLD(HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .sleep_strobe(sleep_strobe), .wake(wake), .sleep_req(sleep_req),
  .sleep_mode(sleep_mode), .bod_off(bod_off)
);

// File: tb/sleep_ctl_reg_bench.sv
module sleep_ctl_reg_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sleep_strobe = 1'b0;
  logic       wake = 1'b0;
  logic [7:0] rd_data;
  logic       sleep_req;
  logic [1:0] sleep_mode;
  logic       bod_off;

  sleep_ctl_reg u_sleep_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sleep_strobe(sleep_strobe), .wake(wake), .sleep_req(sleep_req),
    .sleep_mode(sleep_mode), .bod_off(bod_off)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] rd;
    logic       req;
    logic [1:0] md;
    logic       bo;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // requirement-level model state
  bit       m_se, m_req, m_bo;
  bit [1:0] m_mode, m_smode;
  int       m_win, m_b;

  task automatic step(input bit w, input logic [7:0] d, input bit s, input bit wk, input string tag);
    exp_t e;
    bit set_ok, unl, act;
    wr_en = w; wr_data = d; sleep_strobe = s; wake = wk;
    unl    = w && d[6] && d[5];
    set_ok = w && d[6] && !d[5] && (m_win != 0);
    act    = (m_b != 0) && (m_b <= 3);
    if (wk) begin m_req = 0; m_bo = 0; end
    else if (s && m_se && !m_req) begin m_req = 1; m_smode = m_mode; m_bo = act; end
    m_win = unl ? 4 : set_ok ? 0 : (m_win != 0 ? m_win - 1 : 0);
    m_b   = set_ok ? 6 : (m_b != 0 ? m_b - 1 : 0);
    if (w) begin m_se = d[0]; m_mode = d[2:1]; end
    e.rd  = {1'b0, m_b != 0, m_win != 0, 2'b00, m_mode, m_se};
    e.req = m_req; e.md = m_smode; e.bo = m_bo; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    wr_en = 0; sleep_strobe = 0; wake = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rd_data !== e.rd || sleep_req !== e.req || sleep_mode !== e.md || bod_off !== e.bo) begin
        fails++;
        $display("FAIL %s: got rd=%h req=%b mode=%b bo=%b expected rd=%h req=%b mode=%b bo=%b",
                 e.tag, rd_data, sleep_req, sleep_mode, bod_off, e.rd, e.req, e.md, e.bo);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== 8'h00 || sleep_req !== 1'b0 || sleep_mode !== 2'b00 || bod_off !== 1'b0) begin
      fails++;
      $display("FAIL R1: got rd=%h req=%b mode=%b bo=%b expected all zero", rd_data, sleep_req, sleep_mode, bod_off);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle(2, "R1 idle after reset");

    step(1, 8'h07, 0, 0, "R2 store se and mode");
    step(1, 8'hFF, 0, 0, "R2 reserved bits read zero");
    idle(5, "R2 window lapse");

    step(1, 8'h04, 0, 0, "R3 disable sleep");
    step(0, 8'h00, 1, 0, "R3 strobe ignored with se=0");
    idle(1, "R3 quiet");

    step(1, 8'h05, 0, 0, "R3 enable sleep mode 10");
    step(0, 8'h00, 1, 0, "R3 strobe enters sleep");
    step(1, 8'h03, 0, 0, "R4 rewrite mode while asleep");
    step(0, 8'h00, 1, 0, "R4 strobe ignored while asleep");
    step(0, 8'h00, 0, 1, "R4 wake clears request");
    step(0, 8'h00, 0, 1, "R4 wake when idle");

    for (int m = 0; m < 4; m++) begin
      step(1, {5'b0, 2'(m), 1'b1}, 0, 0, "R10 select mode");
      step(0, 8'h00, 1, 0, "R10 strobe captures mode");
      step(0, 8'h00, 0, 1, "R10 wake");
    end

    step(1, 8'h61, 0, 0, "R5 unlock");
    idle(6, "R5 window self-clears");

    step(1, 8'h41, 0, 0, "R7 set without unlock");
    idle(1, "R7 stays clear");
    step(1, 8'h61, 0, 0, "R7 unlock");
    idle(4, "R7 wait past window");
    step(1, 8'h41, 0, 0, "R7 late set ignored");
    idle(2, "R7 stays clear");

    step(1, 8'h61, 0, 0, "R6 unlock");
    idle(3, "R6 wait inside window");
    step(1, 8'h41, 0, 0, "R6 set at window edge");
    idle(8, "R8 delay and self-clear");

    for (int k = 0; k < 8; k++) begin
      step(1, 8'h63, 0, 0, "R9 unlock");
      step(1, 8'h43, 0, 0, "R9 set");
      idle(k, "R9 wait");
      step(0, 8'h00, 1, 0, "R9 strobe vs active interval");
      step(0, 8'h00, 0, 0, "R9 hold");
      step(0, 8'h00, 0, 1, "R9 wake clears bod_off");
      idle(7, "R9 drain");
    end

    idle(2, "end");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule